// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Capture

This block sits behind an E1 receive framer that has already found frame and CRC4 multiframe alignment. For each timeslot-0 byte, the framer gives a one-cycle strobe, the byte itself, and the frame's position (0 to 15) inside the multiframe. The block reads the international spare bit and the national spare bits out of these bytes. It collects them in working accumulators over the sixteen frames.

When the frame-15 byte arrives, the block copies all eight accumulators into eight host-visible registers in a single cycle. It also raises a sticky "new multiframe" flag. The host polls that flag and then reads the registers through an address/data port. It has one multiframe period, about 2 ms, before the next copy replaces the data. A read made partway through a multiframe always returns the last complete set. If the flag is set again before the host clears it, a sticky overrun flag records the lost set.

Top module: `e1_spare_capture`

## Requirements
- R1: After reset, every register read at addresses 0 to 7 returns 0x00, and both `mf_new` and `mf_lost` are 0.
- R2: Address 0 holds the spare bit from the even frames. The spare bit is `ts0_byte[7]`, the first bit on the line. Frames 0, 2, 4, …, 14 land in bits 7, 6, …, 0 in that order.
- R3: Address 1 holds `ts0_byte[7]` from the odd frames. Frames 1, 3, …, 15 land in bits 7, 6, …, 0 in that order.
- R4: Address 2 holds the remote-alarm bit `ts0_byte[5]` from the odd frames, placed in bits using the same order as R3.
- R5: Addresses 3, 4, 5, 6 and 7 hold national bits Sa4 to Sa8. These come from `ts0_byte[4]`, `[3]`, `[2]`, `[1]` and `[0]` of the odd frames, placed in bits using the same order as R3.
- R6: The host registers change only on an aligned frame-15 strobe. They show the new multiframe on the cycle after that strobe. Reads made before then return the previous multiframe unchanged.
- R7: `mf_new` goes to 1 on the cycle after each aligned frame-15 strobe. It stays at 1 until `clr_wr` is pulsed with `clr_data[0]`=1. If a clear and a new set happen in the same cycle, the set wins.
- R8: `mf_lost` goes to 1 when a new multiframe completes while `mf_new` is still 1 and is not being cleared. It stays at 1 until `clr_wr` is pulsed with `clr_data[1]`=1.
- R9: A strobe with `mf_aligned`=0 is ignored. It captures no bit, copies nothing into the registers and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts0_valid | input | 1 | One-cycle strobe: `ts0_byte` is a timeslot-0 byte |
| ts0_byte | input | 8 | Timeslot-0 byte; bit 7 is the first bit received |
| frame_idx | input | 4 | Position of the frame in the multiframe, 0 to 15 |
| mf_aligned | input | 1 | Upstream multiframe alignment is valid |
| rd_addr | input | 3 | Host register select, 0 to 7 |
| rd_data | output | 8 | Selected host register, combinational |
| clr_wr | input | 1 | Host write strobe for the status flags |
| clr_data | input | 2 | Write-1-to-clear: bit 0 clears `mf_new`, bit 1 clears `mf_lost` |
| mf_new | output | 1 | Sticky flag: a new multiframe set is available |
| mf_lost | output | 1 | Sticky flag: a set was overwritten before it was acknowledged |

## Verification
The hardest case to reach from the ports is a host read that falls in the middle of a multiframe. At that point the accumulators hold a mix of old and new bits, and the host registers must still show only the old set. The bench gets there by sending frames 0 to 7 of a second multiframe, with a different bit pattern, after a first set has been copied. It then reads all eight addresses and completes the multiframe. A second hard case is a clear that lands in the same cycle as a new copy. The bench holds the write strobe during the frame-15 strobe and checks that the flag stays set.

// File: rtl/spare_pkg.sv
package spare_pkg;
  parameter int BYTE_W  = 8;
  parameter int NREG    = 8;
  parameter int FRAMES  = 16;
  localparam int ADDR_W = $clog2(NREG);
  localparam int FIDX_W = $clog2(FRAMES);
  localparam int SLOT_W = FIDX_W - 1;

  typedef logic [NREG-1:0][BYTE_W-1:0] regbank_t;

  // Byte bit feeding each odd-frame register (register 0 is even-frame only)
  function automatic int src_bit(input int k);
    if (k == 1)      return 7;
    else if (k == 2) return 5;
    else             return 7 - k;
  endfunction
endpackage

// File: rtl/spare_accum.sv
module spare_accum
  import spare_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts0_valid,
  input  logic [BYTE_W-1:0] ts0_byte,
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic              mf_aligned,
  output logic              commit,
  output regbank_t          acc_next
);
  regbank_t          acc_q;
  logic              hit;
  logic [SLOT_W-1:0] slot;

  assign hit    = ts0_valid && mf_aligned;
  assign slot   = ~frame_idx[FIDX_W-1:1];
  assign commit = hit && (frame_idx == FIDX_W'(FRAMES-1));

  always_comb begin
    acc_next = acc_q;
    if (hit) begin
      if (!frame_idx[0]) begin
        acc_next[0][slot] = ts0_byte[7];
      end else begin
        for (int k = 1; k < NREG; k++) begin
          acc_next[k][slot] = ts0_byte[src_bit(k)];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (hit) acc_q <= acc_next;
  end

  // R9
  accum_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ts0_valid && mf_aligned) |=> $stable(acc_q));
endmodule

// File: rtl/spare_shadow.sv
module spare_shadow
  import spare_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,
  input  regbank_t acc_next,
  input  logic     clr_wr,
  input  logic [1:0] clr_data,
  output regbank_t shadow,
  output logic     mf_new,
  output logic     mf_lost
);
  logic new_d, lost_d, clr_new, clr_lost;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shadow[g] <= '0;
        else if (commit) shadow[g] <= acc_next[g];
      end
    end
  endgenerate

  assign clr_new  = clr_wr && clr_data[0];
  assign clr_lost = clr_wr && clr_data[1];

  always_comb begin
    new_d  = commit || (mf_new && !clr_new);
    lost_d = (commit && mf_new && !clr_new) || (mf_lost && !clr_lost);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_new  <= 1'b0;
      mf_lost <= 1'b0;
    end else begin
      mf_new  <= new_d;
      mf_lost <= lost_d;
    end
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(shadow));
  // R7
  new_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> mf_new);
  // R7
  new_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[0] && !commit) |=> !mf_new);
  // R8
  lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_lost) |-> $past(mf_new));
endmodule

// File: rtl/e1_spare_capture.sv
module e1_spare_capture
  import spare_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ts0_valid,
  input  logic [7:0] ts0_byte,
  input  logic [3:0] frame_idx,
  input  logic       mf_aligned,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       clr_wr,
  input  logic [1:0] clr_data,
  output logic       mf_new,
  output logic       mf_lost
);
  logic     commit;
  regbank_t acc_next;
  regbank_t shadow;

  spare_accum u_accum (
    .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .ts0_byte(ts0_byte),
    .frame_idx(frame_idx), .mf_aligned(mf_aligned),
    .commit(commit), .acc_next(acc_next));

  spare_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .commit(commit), .acc_next(acc_next),
    .clr_wr(clr_wr), .clr_data(clr_data),
    .shadow(shadow), .mf_new(mf_new), .mf_lost(mf_lost));

  assign rd_data = shadow[rd_addr];
endmodule

// File: tb/e1_spare_capture_tb.sv
module e1_spare_capture_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ts0_valid = 1'b0, mf_aligned = 1'b0, clr_wr = 1'b0;
  logic [7:0] ts0_byte = '0;
  logic [3:0] frame_idx = '0;
  logic [2:0] rd_addr = '0;
  logic [1:0] clr_data = '0;
  logic [7:0] rd_data;
  logic mf_new, mf_lost;

  int checks = 0, errors = 0;
  logic [7:0] exp_cur [8];
  logic [7:0] exp_acc [8];

  always #5 clk = ~clk;

  e1_spare_capture dut_i (.*);

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int f);
    return 8'((seed * 37 + f * 91 + f * f * 13) ^ (seed >> 1));
  endfunction

  task automatic send_frame(input int f, input logic [7:0] b, input bit al, input bit clr = 0,
                            input logic [1:0] cd = 2'b00);
    @(negedge clk);
    ts0_valid = 1; frame_idx = 4'(f); ts0_byte = b; mf_aligned = al;
    clr_wr = clr; clr_data = cd;
    @(negedge clk);
    ts0_valid = 0; clr_wr = 0; clr_data = 0;
    if (al) begin
      if (f % 2 == 0) exp_acc[0][7 - f/2] = b[7];
      else begin
        exp_acc[1][7 - f/2] = b[7];
        exp_acc[2][7 - f/2] = b[5];
        for (int k = 3; k < 8; k++) exp_acc[k][7 - f/2] = b[7 - k];
      end
      if (f == 15) exp_cur = exp_acc;
    end
  endtask

  task automatic send_frames(input int seed, input int lo, input int hi, input bit al);
    for (int f = lo; f <= hi; f++) send_frame(f, pat(seed, f), al);
  endtask

  task automatic check_regs(input string req);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      check(rd_data === exp_cur[a], req, rd_data, exp_cur[a]);
    end
  endtask

  task automatic clear(input logic [1:0] cd);
    @(negedge clk); clr_wr = 1; clr_data = cd;
    @(negedge clk); clr_wr = 0; clr_data = 0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) begin exp_cur[a] = '0; exp_acc[a] = '0; end
    check_regs("R1");
    check(mf_new === 0, "R1 mf_new", mf_new, 0);
    check(mf_lost === 0, "R1 mf_lost", mf_lost, 0);
  endtask

  // R2 R3 R4 R5: bit placement under several patterns
  task automatic t_mapping(input int seed);
    send_frames(seed, 0, 15, 1);
    check(mf_new === 1, "R7 set", mf_new, 1);
    check_regs("R2/R3/R4/R5 map");
    clear(2'b11);
  endtask

  task automatic t_walk();
    // Single one in frame 0 even and frame 15 odd: R2 bit7, R3 bit0
    for (int f = 0; f < 16; f++)
      send_frame(f, (f == 0 || f == 15) ? 8'hFF : 8'h00, 1);
    rd_addr = 0; #1; check(rd_data === 8'h80, "R2 frame0->bit7", rd_data, 8'h80);
    rd_addr = 1; #1; check(rd_data === 8'h01, "R3 frame15->bit0", rd_data, 8'h01);
    rd_addr = 2; #1; check(rd_data === 8'h01, "R4 frame15", rd_data, 8'h01);
    rd_addr = 7; #1; check(rd_data === 8'h01, "R5 Sa8 frame15", rd_data, 8'h01);
    clear(2'b11);
  endtask

  task automatic t_midread();
    send_frames(11, 0, 7, 1);
    check_regs("R6 mid");
    send_frames(11, 8, 14, 1);
    check_regs("R6 before f15");
    send_frames(11, 15, 15, 1);
    check_regs("R6 after f15");
    clear(2'b11);
  endtask

  task automatic t_status();
    send_frames(21, 0, 15, 1);
    check(mf_new === 1 && mf_lost === 0, "R7 single", {mf_lost, mf_new}, 1);
    send_frames(22, 0, 15, 1);
    check(mf_lost === 1, "R8 overrun", mf_lost, 1);
    clear(2'b01);
    check(mf_new === 0 && mf_lost === 1, "R8 sticky", {mf_lost, mf_new}, 2);
    clear(2'b10);
    check(mf_lost === 0, "R8 clear", mf_lost, 0);
    // clear coincides with set: set wins, no overrun since clear taken
    send_frames(23, 0, 15, 1);
    send_frames(24, 0, 14, 1);
    send_frame(15, pat(24, 15), 1, 1, 2'b01);
    check(mf_new === 1, "R7 set wins", mf_new, 1);
    check(mf_lost === 0, "R8 no lost on same-cycle clear", mf_lost, 0);
    check_regs("R6 data");
    clear(2'b11);
  endtask

  task automatic t_nosync();
    for (int f = 0; f < 16; f++) send_frame(f, ~pat(31, f), 0);
    check(mf_new === 0, "R9 no flag", mf_new, 0);
    check_regs("R9 regs unchanged");
    // partial ignored frames then aligned full mf: all bits from aligned data
    send_frames(32, 0, 15, 1);
    check_regs("R9 resume");
    clear(2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_walk();
    t_mapping(3);
    t_mapping(7);
    t_mapping(100);
    t_midread();
    t_status();
    t_nosync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule